// File: doc/BRIEF.md
# Transmit Queue to FIFO Channel Steering Scheduler

This block decides, every clock cycle, which transmit queue may hand its next frame descriptor to the transmit DMA side. It also decides which prioritised DMA FIFO channel receives that descriptor. Sixteen queues share eight channels. Each queue is bound by configuration to exactly one channel, and any number of queues may be bound to the same channel. Channels 0 to 3 carry traffic classes of rising importance: background, best effort, video, and voice plus management. Channels 4 to 6 carry no assigned class. Channel 7 is reserved for commands and outranks all others.

Software programs each queue with one 32-bit configuration word. Each cycle the queue-side logic reports which queues hold descriptors, and each channel reports whether it can accept one. A dispatch is presented combinationally in the cycle it fires. It carries the queue number, the queue's current head descriptor index, the channel, and the queue's acknowledgement mode. At the following clock edge the scheduler advances that queue's head index and moves the round-robin pointer of that channel.

Top module: `txq_steer`

## Requirements
- R1: A configuration write to queue `cfg_qid` takes effect at the next clock edge. The word's bits [2:0] give the channel, bit 3 sets the queue active, and bit 19 requests acknowledgement-window mode. The write also clears that queue's head index to 0.
- R2: A queue whose active bit is clear is never dispatched, whatever its pending input.
- R3: `disp_valid` is 1 exactly when some active, pending queue is bound to a channel whose `ch_ready` bit is 1. A dispatch never targets a channel that is not ready.
- R4: When several channels are eligible, the highest-numbered one wins. The command channel 7 is first, then 6 down to 0, so voice (3) beats video (2), video beats best effort (1), and best effort beats background (0).
- R5: Among eligible queues bound to one channel, the winner is the first queue at or after that channel's pointer, in ascending order with wrap-around. After a dispatch on that channel, the pointer becomes the winner's number plus one, modulo 16.
- R6: `disp_idx` is the dispatched queue's head index. That index rises by exactly one, modulo 256, at the clock edge ending a dispatch cycle, and it does not change otherwise.
- R7: `disp_sack` is the stored bit-19 mode of the dispatched queue. A queue configured onto channel 7 always stores mode 0, so a command dispatch always shows `disp_sack` = 0.
- R8: After reset every queue is inactive with head index 0, and every round-robin pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 4 | Queue addressed by the write |
| cfg_wdata | input | 32 | Configuration word (channel [2:0], active [3], ack mode [19]) |
| q_pend | input | 16 | Per-queue descriptor-pending flags |
| ch_ready | input | 8 | Per-channel ready to accept a descriptor |
| disp_valid | output | 1 | A dispatch fires this cycle |
| disp_qid | output | 4 | Dispatched queue |
| disp_ch | output | 3 | Target channel |
| disp_idx | output | 8 | Head descriptor index of the dispatched queue |
| disp_sack | output | 1 | Acknowledgement-window mode of the dispatched queue |

## Verification
A corrupted round-robin pointer shows up on the next contested dispatch of that channel as a wrong `disp_qid`. A head counter that slips or moves on a non-dispatch cycle shows as a wrong `disp_idx` the next time that queue wins. A bad channel binding or active bit shows within one cycle as a wrong `disp_valid` or `disp_ch`. The bench therefore sweeps every ready mask and every pending pattern of a small default mapping, runs queues past the head wrap, and holds an arithmetic model of pointers and heads that is compared against every cycle.

// File: rtl/txq_steer_pkg.sv
package txq_steer_pkg;
  // Positions of the configuration-word fields.
  localparam int CFG_CH_LSB  = 0;
  localparam int CFG_ACT_BIT = 3;
  localparam int CFG_ACK_BIT = 19;
  localparam int CFG_W       = 32;
endpackage

// File: rtl/txq_cfg_store.sv
module txq_cfg_store
  import txq_steer_pkg::*;
#(
  parameter int NQ     = 16,
  parameter int NCH    = 8,
  parameter int IDX_W  = 8,
  parameter int CMD_CH = 7,
  localparam int QW    = $clog2(NQ),
  localparam int CW    = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [QW-1:0]              cfg_qid,
  input  logic [CFG_W-1:0]           cfg_wdata,
  input  logic                       adv_en,
  input  logic [QW-1:0]              adv_q,
  output logic [NQ-1:0][CW-1:0]      q_ch,
  output logic [NQ-1:0]              q_act,
  output logic [NQ-1:0]              q_ack,
  output logic [NQ-1:0][IDX_W-1:0]   q_head
);
  logic [NQ-1:0][CW-1:0]    ch_nxt;
  logic [NQ-1:0]            act_nxt, ack_nxt;
  logic [NQ-1:0][IDX_W-1:0] head_nxt;
  logic [CW-1:0]            wr_ch;

  assign wr_ch = cfg_wdata[CFG_CH_LSB +: CW];

  always_comb begin
    ch_nxt   = q_ch;
    act_nxt  = q_act;
    ack_nxt  = q_ack;
    head_nxt = q_head;
    for (int i = 0; i < NQ; i++) begin
      if (cfg_we && cfg_qid == QW'(i)) begin
        ch_nxt[i]   = wr_ch;
        act_nxt[i]  = cfg_wdata[CFG_ACT_BIT];
        // command channel is always plain in-order mode
        ack_nxt[i]  = cfg_wdata[CFG_ACK_BIT] && (wr_ch != CW'(CMD_CH));
        head_nxt[i] = '0;
      end else if (adv_en && adv_q == QW'(i)) begin
        head_nxt[i] = q_head[i] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ch   <= '0;
      q_act  <= '0;
      q_ack  <= '0;
      q_head <= '0;
    end else begin
      q_ch   <= ch_nxt;
      q_act  <= act_nxt;
      q_ack  <= ack_nxt;
      q_head <= head_nxt;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    // R6: head moves by one on a dispatch not overridden by a write
    p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && adv_q == QW'(g) && !(cfg_we && cfg_qid == QW'(g)))
      |=> q_head[g] == $past(q_head[g]) + IDX_W'(1));
    // R6: head holds without dispatch or write
    p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(adv_en && adv_q == QW'(g)) && !(cfg_we && cfg_qid == QW'(g)))
      |=> $stable(q_head[g]));
    // R7: command-channel queues never hold ack mode
    p_cmd_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ch[g] == CW'(CMD_CH)) |-> !q_ack[g]);
  end
endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick #(
  parameter int NQ = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] req,
  input  logic          take,
  output logic          gnt_v,
  output logic [QW-1:0] gnt_q
);
  logic [QW-1:0] ptr, ptr_nxt;

  always_comb begin
    gnt_v = 1'b0;
    gnt_q = '0;
    for (int k = 0; k < NQ; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= NQ) idx = idx - NQ;
      if (!gnt_v && req[idx]) begin
        gnt_v = 1'b1;
        gnt_q = QW'(idx);
      end
    end
  end

  always_comb begin
    ptr_nxt = ptr;
    if (take && gnt_v)
      ptr_nxt = (int'(gnt_q) == NQ - 1) ? '0 : gnt_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R5: a grant always lands on a requesting queue
  p_gnt_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v |-> req[gnt_q]);
  // R5: any request yields a grant
  p_req_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> gnt_v);
endmodule

// File: rtl/txq_steer.sv
module txq_steer
  import txq_steer_pkg::*;
#(
  parameter int NQ     = 16,
  parameter int NCH    = 8,
  parameter int IDX_W  = 8,
  parameter int CMD_CH = 7,
  localparam int QW    = $clog2(NQ),
  localparam int CW    = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [NQ-1:0]     q_pend,
  input  logic [NCH-1:0]    ch_ready,
  output logic              disp_valid,
  output logic [QW-1:0]     disp_qid,
  output logic [CW-1:0]     disp_ch,
  output logic [IDX_W-1:0]  disp_idx,
  output logic              disp_sack
);
  logic [NQ-1:0][CW-1:0]    q_ch;
  logic [NQ-1:0]            q_act, q_ack;
  logic [NQ-1:0][IDX_W-1:0] q_head;
  logic [NCH-1:0]           pv;
  logic [NCH-1:0][QW-1:0]   pq;

  txq_cfg_store #(.NQ(NQ), .NCH(NCH), .IDX_W(IDX_W), .CMD_CH(CMD_CH)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_wdata(cfg_wdata), .adv_en(disp_valid), .adv_q(disp_qid),
    .q_ch(q_ch), .q_act(q_act), .q_ack(q_ack), .q_head(q_head));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NQ-1:0] req_c;
    always_comb
      for (int q = 0; q < NQ; q++)
        req_c[q] = q_pend[q] && q_act[q] && (q_ch[q] == CW'(c));
    txq_rr_pick #(.NQ(NQ)) i_pick (
      .clk(clk), .rst_n(rst_n), .req(req_c),
      .take(disp_valid && disp_ch == CW'(c)),
      .gnt_v(pv[c]), .gnt_q(pq[c]));
  end

  // highest-numbered ready channel with a candidate wins
  always_comb begin
    disp_valid = 1'b0;
    disp_ch    = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_ready[c] && pv[c]) begin
        disp_valid = 1'b1;
        disp_ch    = CW'(c);
      end
  end

  assign disp_qid  = pq[disp_ch];
  assign disp_idx  = q_head[disp_qid];
  assign disp_sack = q_ack[disp_qid];

  // R3: dispatch only to a ready channel from a pending queue
  p_ready_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (ch_ready[disp_ch] && q_pend[disp_qid]));
  // R2: only active queues are dispatched
  p_active_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> q_act[disp_qid]);
  // R1: the dispatch channel is the queue's bound channel
  p_binding_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (q_ch[disp_qid] == disp_ch));
  // R7: command dispatches are plain in-order
  p_cmd_sack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ch == CW'(CMD_CH)) |-> !disp_sack);
endmodule

// File: tb/test_txq_steer.sv
`timescale 1ns/1ps
module test_txq_steer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_qid;
  logic [31:0] cfg_wdata;
  logic [15:0] q_pend;
  logic [7:0]  ch_ready;
  logic        disp_valid, disp_sack;
  logic [3:0]  disp_qid;
  logic [2:0]  disp_ch;
  logic [7:0]  disp_idx;

  int errors = 0, checks = 0;
  int m_ch[16], m_act[16], m_ack[16], m_head[16], m_rr[8];

  always #10 clk = ~clk;

  txq_steer i_txq_steer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
    .cfg_wdata(cfg_wdata), .q_pend(q_pend), .ch_ready(ch_ready),
    .disp_valid(disp_valid), .disp_qid(disp_qid), .disp_ch(disp_ch),
    .disp_idx(disp_idx), .disp_sack(disp_sack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int q, input int ch, input int act, input int ack);
    @(negedge clk);
    q_pend    = '0;
    cfg_we    = 1'b1;
    cfg_qid   = 4'(q);
    cfg_wdata = '0;
    cfg_wdata[2:0] = 3'(ch);
    cfg_wdata[3]   = act[0];
    cfg_wdata[19]  = ack[0];
    @(negedge clk);
    cfg_we = 1'b0;
    m_ch[q] = ch; m_act[q] = act; m_ack[q] = (ack != 0 && ch != 7) ? 1 : 0;
    m_head[q] = 0;
  endtask

  // one cycle of stimulus, compared against the requirement model
  task automatic step(input logic [15:0] pend, input logic [7:0] rdy, input string tag);
    bit ev = 0;
    int ec = 0, eq = 0;
    @(negedge clk);
    q_pend = pend; ch_ready = rdy;
    #2;
    for (int c = 0; c < 8; c++) begin
      if (rdy[c]) begin
        for (int k = 0; k < 16; k++) begin
          int q;
          q = (m_rr[c] + k) % 16;
          if (pend[q] && m_act[q] != 0 && m_ch[q] == c) begin
            ev = 1; ec = c; eq = q;
            break;
          end
        end
      end
    end
    chk(disp_valid == ev, {tag, " valid"}, int'(disp_valid), int'(ev));
    if (ev && disp_valid) begin
      chk(disp_ch == 3'(ec), {tag, " channel"}, int'(disp_ch), ec);
      chk(disp_qid == 4'(eq), {tag, " queue"}, int'(disp_qid), eq);
      chk(disp_idx == 8'(m_head[eq]), "R6 head index", int'(disp_idx), m_head[eq]);
      chk(disp_sack == m_ack[eq][0], "R7 ack mode", int'(disp_sack), m_ack[eq]);
    end
    if (ev) begin
      m_head[eq] = (m_head[eq] + 1) % 256;
      m_rr[ec]   = (eq + 1) % 16;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_qid = '0; cfg_wdata = '0;
    q_pend = '0; ch_ready = '0;
    for (int i = 0; i < 16; i++) begin m_ch[i] = 0; m_act[i] = 0; m_ack[i] = 0; m_head[i] = 0; end
    for (int i = 0; i < 8; i++) m_rr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: after reset nothing is active, so nothing dispatches
    step(16'hFFFF, 8'hFF, "R8 reset");
    step(16'hFFFF, 8'hFF, "R8 reset");

    // R1: default binding q -> same-numbered channel; odd queues ack mode; q7 is command
    for (int q = 0; q < 8; q++) cfg(q, q, 1, (q % 2 == 1) ? 1 : 0);

    // R4: every ready mask with all queues pending
    for (int r = 0; r < 256; r++) step(16'h00FF, 8'(r), "R4 priority");
    // R3: every pending pattern of the low queues with all channels ready
    for (int p = 0; p < 256; p++) step(16'(p), 8'hFF, "R3 pending");
    // R3: no ready channel, no dispatch
    step(16'hFFFF, 8'h00, "R3 none ready");

    // R5: four queues share channel 1
    cfg(8, 1, 1, 0); cfg(9, 1, 1, 1); cfg(10, 1, 1, 0);
    for (int i = 0; i < 10; i++) step(16'hFFFF, 8'h02, "R5 round robin");
    step(16'h0502, 8'h02, "R5 sparse");
    step(16'h0502, 8'h02, "R5 sparse");
    step(16'h0502, 8'h02, "R5 sparse");

    // R2: queue 9 deactivated; pending alone it never wins
    cfg(9, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(16'h0200, 8'hFF, "R2 inactive");
    step(16'h0602, 8'h02, "R2 mixed");

    // R7: command queue written with ack request still reports plain mode
    cfg(7, 7, 1, 1);
    step(16'h0080, 8'hFF, "R7 command");
    cfg(12, 3, 1, 1);
    step(16'h1000, 8'h08, "R7 ack queue");

    // R6: queue 11 alone on channel 5, run past the head wrap
    cfg(11, 5, 1, 0);
    for (int i = 0; i < 300; i++) step(16'h0800, 8'h20, "R6 wrap");
    step(16'h0800, 8'h00, "R6 hold");
    step(16'h0800, 8'h20, "R6 after hold");
    // R1: rewriting clears head
    cfg(11, 5, 1, 0);
    step(16'h0800, 8'h20, "R1 head clear");

    // mixed pseudo-random traffic over the whole configuration
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr, lfsr[15:8] ^ lfsr[7:0], "R4 R5 mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule